// File: doc/BRIEF.md
# Programmable Serial Test-Pattern Generator

This block feeds the transmit side of a bit-error-rate tester with a serial test stream, one bit per enabled clock. Three pattern families are available. The first is a pseudo-random sequence from a feedback shift register whose length and tap point are chosen at run time. The second is a word of up to 32 bits that repeats endlessly. The third is a fixed quasi-random signal source from a 20-stage register. The quasi-random source also caps the number of consecutive zeros it sends.

Configuration and seed are captured only when `load` is high. In the same cycle the shift register is primed. After that the outside fields may change freely. The output works like a stream with no valid flag. `ser_bit` always shows the current bit. The consumer takes that bit by raising `bit_en` for one clock. The next bit then appears after the same edge. While `bit_en` stays low, the output holds its value indefinitely, and this is the only back-pressure.

Top module: `bert_pattern_gen`

## Requirements
- R1: A synchronous reset clears the captured configuration to zero (length field 0, tap field 0, pseudo-random mode, quasi-random off) and sets the state to stage 1 only, so `ser_bit` reads 1 after reset. The first enabled bit after reset then reads 0.
- R2: A pulse on `load` captures `qrss_en`, `rep_mode`, `len_sel`, `tap_sel` and `seed_word`. When `load` and `bit_en` are high together, `load` wins. When `load` is low, changes on those inputs have no effect on the output sequence.
- R3: With `rep_mode` = 0, the register length is n = `len_sel`+1 and the tap stage is y = `tap_sel`+1. On each enabled clock, stage n XOR stage y enters stage 1 and every stage moves up one. Stages above n are held at zero, so a tap beyond n reads 0.
- R4: In pseudo-random mode, a load whose seed is zero in its low n bits primes all n stages with ones instead.
- R5: With `rep_mode` = 1, the low n bits of the seed word rotate and are sent most significant first: bit k of the output stream is `seed_word[n-1 - (k mod n)]`. `tap_sel` has no effect in this mode.
- R6: In repetitive mode, an all-zero word is kept as zeros and gives a constant 0 stream.
- R7: With `qrss_en` = 1 at load, the length, tap, type and seed inputs are ignored. The register runs x^20 + x^17 + 1 (n = 20, y = 17) from an all-ones start.
- R8: In quasi-random mode, `ser_bit` is forced to 1 whenever the fourteen stages that follow the output stage (stages 19 down to 6) are all zero. The forced value does not enter the register. No run of more than fourteen zeros is ever sent.
- R9: `ser_bit` does not change on any clock where neither `bit_en` nor `load` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Consumer takes the current bit and advances the pattern |
| load | input | 1 | Capture configuration and seed, prime the register |
| qrss_en | input | 1 | Select the fixed quasi-random source |
| rep_mode | input | 1 | 0 = pseudo-random, 1 = repetitive word |
| len_sel | input | 5 | Register length minus one |
| tap_sel | input | 5 | Feedback tap stage minus one |
| seed_word | input | 32 | Seed or repeating word |
| ser_bit | output | 1 | Current serial pattern bit |

## Verification
A wrong stage, tap or mask value changes the stream within at most n enabled bits. The output stage is always read directly, and any register error reaches stage n within n shifts. A wrong feedback therefore shows as a mismatch within roughly 2n bits, and a wrong period shows as a changed ones-count over one full cycle. Errors in the zero-run limiter appear only when a long zero run comes near. Such runs are rare in the 20-stage sequence, so the quasi-random stream is compared over a long run that contains several of them.

// File: rtl/bpg_pkg.sv
`timescale 1ns/1ps
package bpg_pkg;
  localparam int BPG_W  = 32;
  localparam int BPG_FW = $clog2(BPG_W);

  typedef struct packed {
    logic              qrss;
    logic              rep;
    logic [BPG_FW-1:0] len;
    logic [BPG_FW-1:0] tap;
  } bpg_cfg_t;
endpackage

// File: rtl/bpg_cfg.sv
`timescale 1ns/1ps
module bpg_cfg
  import bpg_pkg::*;
#(
  parameter int QLEN = 20,
  parameter int QTAP = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              qrss_in,
  input  logic              rep_in,
  input  logic [BPG_FW-1:0] len_in,
  input  logic [BPG_FW-1:0] tap_in,
  output bpg_cfg_t          cfg_q,
  output bpg_cfg_t          cfg_nx
);
  bpg_cfg_t raw;

  always_comb begin
    raw = load ? bpg_cfg_t'{qrss: qrss_in, rep: rep_in, len: len_in, tap: tap_in} : cfg_q;
    cfg_nx = raw;
    if (raw.qrss) begin
      cfg_nx.rep = 1'b0;
      cfg_nx.len = BPG_FW'(QLEN - 1);
      cfg_nx.tap = BPG_FW'(QTAP - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_nx;
  end

  p_qrss_fixed_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_q.qrss |-> (cfg_q.len == BPG_FW'(QLEN - 1) && cfg_q.tap == BPG_FW'(QTAP - 1) && !cfg_q.rep));

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load)) |-> $stable(cfg_q));
endmodule

// File: rtl/bpg_lfsr.sv
`timescale 1ns/1ps
module bpg_lfsr
  import bpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             bit_en,
  input  logic [BPG_W-1:0] seed,
  input  bpg_cfg_t         cfg,
  output logic [BPG_W-1:0] state
);
  logic [BPG_W-1:0] mask;
  logic [BPG_W-1:0] base;
  logic             fb;

  for (genvar i = 0; i < BPG_W; i++) begin : g_mask
    assign mask[i] = (cfg.len >= BPG_FW'(i));
  end

  always_comb begin
    base = (cfg.qrss ? '1 : seed) & mask;
    if (!cfg.rep && base == '0) base = mask;
    fb = cfg.rep ? state[cfg.len] : (state[cfg.len] ^ state[cfg.tap]);
  end

  always_ff @(posedge clk) begin
    if (rst)         state <= BPG_W'(1);
    else if (load)   state <= base;
    else if (bit_en) state <= {state[BPG_W-2:0], fb} & mask;
  end

  p_load_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load) && !$past(cfg.rep)) |-> (state != '0));

  p_rotate_keeps_ones_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bit_en) && !$past(load) && $past(cfg.rep))
      |-> ($countones(state) == $countones($past(state))));
endmodule

// File: rtl/bpg_qrss_limit.sv
`timescale 1ns/1ps
module bpg_qrss_limit
  import bpg_pkg::*;
#(
  parameter int QLEN = 20,
  parameter int ZRUN = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             bit_en,
  input  logic [BPG_W-1:0] state,
  input  bpg_cfg_t         cfg,
  output logic             ser_bit
);
  localparam int CW = $clog2(ZRUN + 2);

  logic       zero_ahead;
  logic [CW-1:0] run_cnt;

  assign zero_ahead = (state[QLEN-2 -: ZRUN] == '0);
  assign ser_bit    = state[cfg.len] | (cfg.qrss & zero_ahead);

  always_ff @(posedge clk) begin
    if (rst || load)                 run_cnt <= '0;
    else if (bit_en && cfg.qrss) begin
      if (ser_bit) run_cnt <= '0;
      else         run_cnt <= run_cnt + 1'b1;
    end
  end

  p_zero_run_r8: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= CW'(ZRUN));
endmodule

// File: rtl/bert_pattern_gen.sv
`timescale 1ns/1ps
module bert_pattern_gen
  import bpg_pkg::*;
#(
  parameter int QLEN = 20,
  parameter int QTAP = 17,
  parameter int ZRUN = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              load,
  input  logic              qrss_en,
  input  logic              rep_mode,
  input  logic [BPG_FW-1:0] len_sel,
  input  logic [BPG_FW-1:0] tap_sel,
  input  logic [BPG_W-1:0]  seed_word,
  output logic              ser_bit
);
  bpg_cfg_t         cfg_q;
  bpg_cfg_t         cfg_nx;
  logic [BPG_W-1:0] state;

  bpg_cfg #(.QLEN(QLEN), .QTAP(QTAP)) i_cfg (
    .clk(clk), .rst(rst), .load(load), .qrss_in(qrss_en), .rep_in(rep_mode),
    .len_in(len_sel), .tap_in(tap_sel), .cfg_q(cfg_q), .cfg_nx(cfg_nx)
  );

  bpg_lfsr i_lfsr (
    .clk(clk), .rst(rst), .load(load), .bit_en(bit_en),
    .seed(seed_word), .cfg(cfg_nx), .state(state)
  );

  bpg_qrss_limit #(.QLEN(QLEN), .ZRUN(ZRUN)) i_lim (
    .clk(clk), .rst(rst), .load(load), .bit_en(bit_en),
    .state(state), .cfg(cfg_q), .ser_bit(ser_bit)
  );

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bit_en) && !$past(load)) |-> $stable(ser_bit));
endmodule

// File: tb/test_bert_pattern_gen.sv
`timescale 1ns/1ps
module test_bert_pattern_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic        load = 1'b0;
  logic        qrss_en = 1'b0;
  logic        rep_mode = 1'b0;
  logic [4:0]  len_sel = '0;
  logic [4:0]  tap_sel = '0;
  logic [31:0] seed_word = '0;
  logic        ser_bit;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bert_pattern_gen i_bert_pattern_gen (
    .clk(clk), .rst(rst), .bit_en(bit_en), .load(load), .qrss_en(qrss_en),
    .rep_mode(rep_mode), .len_sel(len_sel), .tap_sel(tap_sel),
    .seed_word(seed_word), .ser_bit(ser_bit)
  );

  always #2 clk = ~clk;

  // reference model state
  logic [31:0] ms;
  int          ml, mt;
  bit          mrep, mq;

  function automatic logic [31:0] mk(int l);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (i <= l);
    return m;
  endfunction

  function automatic bit m_raw();
    return ms[ml];
  endfunction

  function automatic bit m_out();
    return ms[ml] | (mq && ms[18:5] == 14'd0);
  endfunction

  task automatic m_step();
    bit fb;
    fb = mrep ? ms[ml] : (ms[ml] ^ ((mt <= ml) ? ms[mt] : 1'b0));
    ms = {ms[30:0], fb} & mk(ml);
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(bit en);
    bit_en = en;
    @(posedge clk);
    #1;
    bit_en = 1'b0;
  endtask

  task automatic ld(bit q, bit r, int l, int t, logic [31:0] s, bit en);
    qrss_en = q; rep_mode = r; len_sel = 5'(l); tap_sel = 5'(t); seed_word = s;
    load = 1'b1; bit_en = en;
    @(posedge clk);
    #1;
    load = 1'b0; bit_en = 1'b0;
    mq = q;
    if (q) begin
      mrep = 1'b0; ml = 19; mt = 16; ms = mk(19);
    end else begin
      mrep = r; ml = l; mt = t; ms = s & mk(l);
      if (!r && ms == 0) ms = mk(l);
    end
  endtask

  // compare n bits with model; returns mismatches
  task automatic run_cmp(int nb, output int bad, output int first_i,
                         output bit a0, output bit e0);
    bad = 0; first_i = -1; a0 = 0; e0 = 0;
    for (int i = 0; i < nb; i++) begin
      if (ser_bit !== m_out()) begin
        if (bad == 0) begin first_i = i; a0 = ser_bit; e0 = m_out(); end
        bad++;
      end
      tick(1'b1);
      m_step();
    end
  endtask

  initial begin
    #(199000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int  bad, fi;
    bit  a, e;
    bit  seq[254];
    int  ones;
    logic [31:0] w;

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk(ser_bit === 1'b1, "R1", "output after reset", ser_bit, 1);
    tick(1'b1);
    chk(ser_bit === 1'b0, "R1", "first bit after reset (n=1,y=1)", ser_bit, 0);

    // R2 load wins over bit_en
    ld(0, 0, 7, 3, 32'h0000_00A5, 1'b1);
    chk(ser_bit === 1'b1, "R2", "load with bit_en shows stage 8 of seed", ser_bit, 1);
    run_cmp(40, bad, fi, a, e);
    chk(bad == 0, "R2", "sequence after load", a, e);

    // R2 inputs ignored without load
    ld(0, 0, 11, 2, 32'h0000_0ABC, 1'b0);
    len_sel = 5'd30; tap_sel = 5'd1; seed_word = 32'hFFFF_0000; rep_mode = 1'b1; qrss_en = 1'b1;
    run_cmp(60, bad, fi, a, e);
    chk(bad == 0, "R2", "fields changed without load", a, e);

    // R3 sweep all length/tap pairs
    for (int l = 0; l < 32; l++) begin
      for (int t = 0; t < 32; t++) begin
        w = 32'h9E37_79B9 ^ (32'(l) << 7) ^ (32'(t) * 32'h0101_0101);
        ld(0, 0, l, t, w, 1'b0);
        run_cmp(l + 4, bad, fi, a, e);
        chk(bad == 0, "R3", $sformatf("prbs len=%0d tap=%0d bit %0d", l, t, fi), a, e);
      end
    end

    // R3 maximal sequence n=7,y=6: period 127 with 64 ones
    ld(0, 0, 6, 5, 32'h1, 1'b0);
    for (int i = 0; i < 254; i++) begin seq[i] = ser_bit; tick(1'b1); end
    ones = 0; bad = 0;
    for (int i = 0; i < 127; i++) begin
      ones += seq[i];
      if (seq[i] != seq[i + 127]) bad++;
    end
    chk(bad == 0, "R3", "period 127 repeat mismatches", bad, 0);
    chk(ones == 64, "R3", "ones in one period", ones, 64);

    // R4 zero seed primes ones
    ld(0, 0, 9, 4, 32'hFFFF_FC00, 1'b0);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      if (ser_bit !== 1'b1) bad++;
      tick(1'b1);
    end
    chk(bad == 0, "R4", "zero bits among first 10 after zero seed", bad, 0);

    // R5 repetitive sweep, arithmetic expectation, two taps
    for (int l = 0; l < 32; l++) begin
      for (int tv = 0; tv < 2; tv++) begin
        w = 32'hC3A5_1E69 ^ (32'(l) * 32'h0011_0003);
        ld(0, 1, l, tv ? 31 - l : l / 2, w, 1'b0);
        bad = 0; a = 0; e = 0;
        for (int k = 0; k < 2 * (l + 1) + 3; k++) begin
          if (ser_bit !== w[l - (k % (l + 1))]) begin
            if (bad == 0) begin a = ser_bit; e = w[l - (k % (l + 1))]; end
            bad++;
          end
          tick(1'b1);
        end
        chk(bad == 0, "R5", $sformatf("rotate len=%0d tapvar=%0d", l, tv), a, e);
      end
    end

    // R6 zero word in repetitive mode
    ld(0, 1, 12, 3, 32'hFFFF_E000, 1'b0);
    bad = 0;
    for (int i = 0; i < 40; i++) begin if (ser_bit !== 1'b0) bad++; tick(1'b1); end
    chk(bad == 0, "R6", "ones in zero-word stream", bad, 0);

    // R9 hold while idle
    ld(0, 0, 15, 8, 32'h0000_5A3C, 1'b0);
    repeat (3) tick(1'b1);
    repeat (3) m_step();
    a = ser_bit; bad = 0;
    for (int i = 0; i < 8; i++) begin if (ser_bit !== a) bad++; tick(1'b0); end
    chk(bad == 0, "R9", "output changes while idle", bad, 0);
    chk(ser_bit === m_out(), "R9", "bit after idle", ser_bit, m_out());

    // R7 QRSS ignores fields: two different loads give same start
    ld(1, 1, 3, 2, 32'h0, 1'b0);
    run_cmp(64, bad, fi, a, e);
    chk(bad == 0, "R7", "qrss start sequence (set A)", a, e);
    ld(1, 0, 28, 30, 32'h1234_5678, 1'b0);
    run_cmp(64, bad, fi, a, e);
    chk(bad == 0, "R7", "qrss start sequence (set B)", a, e);

    // R7/R8 long qrss run with zero-run limiting
    ld(1, 0, 0, 0, 32'h0, 1'b0);
    begin
      int zr, zmax, forced;
      bad = 0; zr = 0; zmax = 0; forced = 0; a = 0; e = 0;
      for (int i = 0; i < 160000; i++) begin
        if (ser_bit !== m_out()) begin
          if (bad == 0) begin a = ser_bit; e = m_out(); end
          bad++;
        end
        if (m_out() && !m_raw()) forced++;
        if (ser_bit === 1'b0) begin zr++; if (zr > zmax) zmax = zr; end
        else zr = 0;
        tick(1'b1);
        m_step();
      end
      chk(bad == 0, "R7", "qrss long-run mismatches", a, e);
      chk(forced > 0, "R8", "forced ones seen", forced, 1);
      chk(zmax <= 14, "R8", "longest zero run", zmax, 14);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule